// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block provides a two-address, byte-wide access window onto a file of 256 eight-bit configuration registers. A host first writes a register number to the index address and then reads or writes the selected register through the data address. Reads through either address return the register that the index currently selects, so software can confirm a value right after loading the index.

Only a sparse set of registers in the upper part of the file can be changed. Writes to every other register, including all of the lower range, are dropped without effect. An external enable input gates the whole port. While the enable is low, reads return all ones and writes change nothing. Reset sets the index to zero, loads six registers with fixed default values and clears all other registers.

The host bus is synchronous. It has an address bit, a write strobe, a read strobe and an 8-bit data path in each direction. Read data is registered and appears on the clock edge that samples the read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the index is 0x00 and rdata is 0xFF. Registers 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 hold 0x3C, 0x03, 0xFC, 0xDE, 0xFE and 0xBE. Every other register holds 0x00.
- R2: A write with addr=0 while port_en=1 loads wdata into the index. The new index is in effect from the next cycle.
- R3: A write with addr=1 while port_en=1 stores wdata into the indexed register when the index is one of 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC.
- R4: A write with addr=1 to any other index leaves the register file unchanged. This covers 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF.
- R5: A read strobe with port_en=1 and either value of addr loads rdata with the indexed register, as it stood before any write in the same cycle.
- R6: While port_en=0, a read strobe loads rdata with 0xFF, and writes change neither the index nor any register.
- R7: A write to the index changes no register, and the index keeps its value until the next enabled index write.
- R8: rdata keeps its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port decode enable |
| addr | input | 1 | 0 selects the index, 1 selects the data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
Every result appears one clock edge after its stimulus. An index write or data write takes effect at the edge that samples the strobe. A read loads rdata at that same edge, using the state from before that edge. The bench drives inputs on the falling edge and compares rdata on the next falling edge, which is half a period after the edge that updated it. Its reference model computes the read value from its pre-edge state and only then applies the write, which matches the one-edge timing of the design.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [DW-1:0] IDLE_READ = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] idx;
  logic [DW-1:0] cfg [DEPTH];
  logic [DW-1:0] cfg_sel;

  function automatic logic wr_ok(input logic [AW-1:0] i);
    int v;
    v = int'(i);
    return (v >= 'hE0 && v <= 'hE3) || (v >= 'hE6 && v <= 'hE8) ||
           (v >= 'hEE && v <= 'hF2) || v == 'hF4 || v == 'hF6 ||
           v == 'hF8 || v == 'hFC;
  endfunction

  function automatic logic [DW-1:0] dflt(input int i);
    case (i)
      'hE0: return DW'(8'h3C);
      'hE2: return DW'(8'h03);
      'hE3: return DW'(8'hFC);
      'hE6: return DW'(8'hDE);
      'hE7: return DW'(8'hFE);
      'hE8: return DW'(8'hBE);
      default: return '0;
    endcase
  endfunction

  assign cfg_sel = cfg[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      rdata <= IDLE_READ;
      for (int i = 0; i < DEPTH; i++) cfg[i] <= dflt(i);
    end else begin
      if (rd) rdata <= port_en ? cfg_sel : IDLE_READ;
      if (wr && port_en) begin
        if (!addr) idx <= AW'(wdata);
        else if (wr_ok(idx)) cfg[idx] <= wdata;
      end
    end
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_en,
  input logic          addr,
  input logic          wr,
  input logic          rd,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [AW-1:0] idx,
  input logic [DW-1:0] sel
);
  a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && port_en && !addr) |=> (idx == $past(AW'(wdata))));

  a_r7_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && port_en && !addr) |=> $stable(idx));

  a_r6_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !port_en) |=> (rdata == '1));

  a_r5_read_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && port_en) |=> (rdata == $past(sel)));

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  a_r4_low_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr && int'(idx) < 'hE0) |=> $stable(sel));

  a_r3_store_e0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && port_en && addr && int'(idx) == 'hE0) |=> (sel == $past(wdata)));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .addr(addr), .wr(wr),
  .rd(rd), .wdata(wdata), .rdata(rdata), .idx(idx), .sel(cfg_sel)
);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
  logic clk = 0, rst_n = 0, port_en = 0, addr = 0, wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  int checks = 0, fails = 0;
  logic [7:0] m_cfg [256];
  logic [7:0] m_idx, m_rd;
  logic done = 0;

  sio_cfg_port u0 (.clk(clk), .rst_n(rst_n), .port_en(port_en), .addr(addr),
    .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata));

  always #10 clk = ~clk;

  function automatic logic may_write(input int i);
    int ok_list [14] = '{'hE0,'hE1,'hE2,'hE3,'hE6,'hE7,'hE8,'hEE,'hEF,'hF0,'hF1,'hF2,'hF4,'hF6};
    foreach (ok_list[k]) if (ok_list[k] == i) return 1;
    return (i == 'hF8) || (i == 'hFC);
  endfunction

  function automatic logic [7:0] reset_val(input int i);
    if (i == 'hE0) return 8'h3C;
    if (i == 'hE2) return 8'h03;
    if (i == 'hE3) return 8'hFC;
    if (i == 'hE6) return 8'hDE;
    if (i == 'hE7) return 8'hFE;
    if (i == 'hE8) return 8'hBE;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic op(input logic en, input logic a, input logic w, input logic r,
                    input logic [7:0] d, input string req);
    port_en = en; addr = a; wr = w; rd = r; wdata = d;
    @(posedge clk);
    if (r) m_rd = en ? m_cfg[m_idx] : 8'hFF;
    if (w && en) begin
      if (!a) m_idx = d;
      else if (may_write(int'(m_idx))) m_cfg[m_idx] = d;
    end
    @(negedge clk);
    port_en = 0; wr = 0; rd = 0;
    if (r) chk(req, rdata, m_rd);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_cfg[i] = reset_val(i);
    m_idx = 0; m_rd = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 rdata reset", rdata, 8'hFF);
    rst_n = 1;
    @(negedge clk);
    op(1, 1, 0, 1, 0, "R1 index reset selects 00");
    for (int i = 0; i < 256; i++) begin
      op(1, 0, 1, 0, 8'(i), "R2");
      op(1, i[0], 0, 1, 0, "R1 R5 default readback");
    end
    op(1, 0, 1, 0, 8'hE0, "R2");
    op(1, 1, 1, 0, 8'h5A, "R3");
    op(1, 0, 0, 1, 0, "R3 write E0 via index port read");
    op(1, 0, 1, 0, 8'h10, "R2");
    op(1, 1, 1, 0, 8'hAA, "R4");
    op(1, 1, 0, 1, 0, "R4 low range protected");
    op(1, 0, 1, 0, 8'hFF, "R2");
    op(1, 1, 1, 0, 8'h77, "R4");
    op(1, 1, 0, 1, 0, "R4 FF protected");
    op(1, 0, 1, 0, 8'hFC, "R2");
    op(1, 1, 1, 0, 8'h33, "R3");
    op(0, 0, 1, 0, 8'h00, "R6");
    op(0, 1, 1, 0, 8'h99, "R6");
    op(0, 1, 0, 1, 0, "R6 disabled read");
    op(1, 1, 0, 1, 0, "R6 R7 index and data kept while disabled");
    op(1, 1, 1, 1, 8'h44, "R5 read before same-cycle write");
    op(1, 1, 0, 1, 0, "R3 same-cycle write landed");
    op(1, 0, 0, 0, 0, "R8");
    repeat (4) @(negedge clk);
    chk("R8 rdata hold", rdata, m_rd);
    void'($urandom(32'd20240607));
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      logic [7:0] d = r[15:8];
      if (r[18:16] < 3) d = 8'hE0 + 8'(r[12:8]);
      op(r[0] | r[1], r[2], r[3], r[4] | ~r[3], d, "R2 R3 R4 R5 R6 R7 random");
    end
    for (int i = 0; i < 256; i++) begin
      op(1, 0, 1, 0, 8'(i), "R2");
      op(1, 1, 0, 1, 0, "R3 R4 final file compare");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule